// File: doc/BRIEF.md
# Staged Maskable and Non-Maskable Interrupt Recognizer

This block decides when a small 8-bit processor core must take an interrupt. It watches the active-low maskable (IRQ) and non-maskable (NMI) request lines. Each request passes through three registered stages. Stage 0 synchronizes the line on phase-2 strobes. Stage 1 latches a pending request on the phase-1 strobe that follows. Stage 2 is the pending-interrupt flag, and it is set only at an instruction boundary. When stage 2 is set, the core replaces the next fetched opcode with BRK, and the break bit goes low.

Only a boundary can promote a request, so the running instruction always finishes first. For non-branch opcodes the boundary is T0. Branch opcodes promote at T2, or at T0 when they cross a page. The BRK sequence tells the block where it stands through its T6 and T0 strobes. The block uses them to clear stage 2, to hold off IRQ for one cycle, to drop NMI stage 1 and to request that the interrupt-disable flag be set. The NMI detector fires once per falling edge. It is armed again only after the BRK sequence has cleared NMI stage 1 and the line has also been seen high.

The design runs on one clock. Two enable strobes, `ph1_en` and `ph2_en`, mark the edges that count as phase 1 and phase 2.

Top module: `irqnmi_stager`

## Requirements
- R1: After reset, `force_brk` and `nmi_vec_sel` are 0, `set_idis` is 0 while no BRK T0 phase-1 strobe is present, `brk_bit` is 1 while `rst_stage2` is 0, and the NMI detector is armed.
- R2: A request line is sampled only on phase-2 edges. With the default single synchronizer stage, a line held low from before one phase-2 edge reaches stage 1 at the next phase-1 edge. It cannot promote in the cycle in which it was first sampled.
- R3: For a non-branch opcode (`is_branch`=0), stage 2 is set at the phase-2 edge of T0 when a request can promote. T2 has no effect.
- R4: For a branch opcode (`is_branch`=1), stage 2 is set at the phase-2 edge of T2. At T0 it is set only when `br_pgcross`=1.
- R5: A latched IRQ does not promote while `idis_flag`=1. It stays pending while the line is low, and it promotes at the first boundary after the flag clears.
- R6: NMI stage 1 promotes regardless of `idis_flag`, and `nmi_vec_sel` goes high at the phase-1 edge that latches NMI stage 1.
- R7: `brk_bit` is 0 whenever `force_brk` is 1 or `rst_stage2` is 1. Otherwise it is 1.
- R8: A phase-2 edge with `brk_t6`=1 clears `force_brk`. A latched IRQ cannot promote at the next phase-2 edge, but it can promote at the phase-2 edge after that.
- R9: `set_idis` is high exactly while `brk_t0` and `ph1_en` are both high. The phase-1 edge with `brk_t0`=1 clears `nmi_vec_sel`.
- R10: After the BRK T0 clear, a new NMI falling edge is accepted only once the NMI line has also been sampled high. The line may rise before or after the clear. An NMI held low across the clear is not taken again.
- R11: IRQ stage 1 clears at the first phase-1 edge after the line is sampled high. A request withdrawn before a boundary is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph1_en | input | 1 | This edge clocks in phase 1 |
| ph2_en | input | 1 | This edge clocks in phase 2 |
| irq_n | input | 1 | Maskable request, active low |
| nmi_n | input | 1 | Non-maskable request, active low, edge detected |
| idis_flag | input | 1 | Interrupt-disable flag from the status register |
| t0_st | input | 1 | Timing generator is in T0 |
| t2_st | input | 1 | Timing generator is in T2 |
| is_branch | input | 1 | Current opcode is a conditional branch |
| br_pgcross | input | 1 | Current branch crosses a page |
| brk_t6 | input | 1 | BRK sequence is in its T6 cycle |
| brk_t0 | input | 1 | BRK sequence is in its closing T0 cycle |
| rst_stage2 | input | 1 | Reset recognition has reached its stage 2 |
| force_brk | output | 1 | Substitute BRK at the next fetch |
| nmi_vec_sel | output | 1 | Select the NMI vector for the BRK sequence |
| brk_bit | output | 1 | Break bit value for the pushed status |
| set_idis | output | 1 | Strobe that sets the interrupt-disable flag |

## Verification
The bench builds the block with the default `SYNC_STAGES`=1. At that depth a request goes from line to stage 2 in one cycle plus one boundary, so each boundary case can be hit at a known edge. The bench walks every combination of opcode kind, T-state and page-cross that bears on promotion. It also walks both orders of NMI re-arming and the one-cycle IRQ hold-off after BRK T6. A request is placed a fixed number of half-cycles before each of these events.

// File: rtl/irqnmi_pkg.sv
package irqnmi_pkg;

    // Registered state of the NMI edge detector
    typedef struct packed {
        logic armed;   // a new falling edge may be latched
        logic pend;    // BRK cleared stage 1, waiting for line high
        logic s1;      // NMI stage 1
    } nmi_st_t;

    // Registered state of the IRQ / stage-2 core
    typedef struct packed {
        logic irq_s1;  // IRQ stage 1
        logic irq_blk; // one-cycle hold-off after BRK T6
        logic int_s2;  // pending-interrupt (stage 2)
    } core_st_t;

    localparam nmi_st_t  NMI_RST  = '{armed: 1'b1, pend: 1'b0, s1: 1'b0};
    localparam core_st_t CORE_RST = '{irq_s1: 1'b0, irq_blk: 1'b0, int_s2: 1'b0};

endpackage

// File: rtl/irqnmi_line_sync.sv
module irqnmi_line_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ph2_en,
    input  logic line_n,
    output logic act
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (ph2_en) begin
            sh_d[0] = ~line_n;
            for (int i = 1; i < STAGES; i++) begin
                sh_d[i] = sh_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign act = sh_q[LAST];
endmodule

// File: rtl/irqnmi_nmi_arm.sv
module irqnmi_nmi_arm
    import irqnmi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ph1_en,
    input  logic nmi_act,
    input  logic brk_t0,
    output logic nmi_s1
);
    nmi_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ph1_en && brk_t0) begin
            // closing BRK cycle drops stage 1; an edge arriving now waits a cycle
            st_d.s1 = 1'b0;
            if (!st_q.armed) st_d.pend = 1'b1;
        end else if (ph1_en && st_q.armed && nmi_act) begin
            st_d.s1    = 1'b1;
            st_d.armed = 1'b0;
        end
        // re-arm once the clear happened and the line is seen inactive
        if (st_q.pend && !nmi_act) begin
            st_d.armed = 1'b1;
            st_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= NMI_RST;
        else        st_q <= st_d;
    end

    assign nmi_s1 = st_q.s1;
endmodule

// File: rtl/irqnmi_stager.sv
module irqnmi_stager
    import irqnmi_pkg::*;
#(
    parameter int SYNC_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ph1_en,
    input  logic ph2_en,
    input  logic irq_n,
    input  logic nmi_n,
    input  logic idis_flag,
    input  logic t0_st,
    input  logic t2_st,
    input  logic is_branch,
    input  logic br_pgcross,
    input  logic brk_t6,
    input  logic brk_t0,
    input  logic rst_stage2,
    output logic force_brk,
    output logic nmi_vec_sel,
    output logic brk_bit,
    output logic set_idis
);
    logic     irq_act, nmi_act, nmi_s1;
    logic     boundary, promote;
    core_st_t st_d, st_q;

    irqnmi_line_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
        .clk(clk), .rst_n(rst_n), .ph2_en(ph2_en), .line_n(irq_n), .act(irq_act)
    );

    irqnmi_line_sync #(.STAGES(SYNC_STAGES)) u_nmi_sync (
        .clk(clk), .rst_n(rst_n), .ph2_en(ph2_en), .line_n(nmi_n), .act(nmi_act)
    );

    irqnmi_nmi_arm u_nmi_arm (
        .clk(clk), .rst_n(rst_n), .ph1_en(ph1_en), .nmi_act(nmi_act),
        .brk_t0(brk_t0), .nmi_s1(nmi_s1)
    );

    always_comb begin
        // branches end at T2, or at T0 after a page cross
        boundary = is_branch ? (t2_st || (t0_st && br_pgcross)) : t0_st;
        promote  = nmi_s1 || (st_q.irq_s1 && !idis_flag && !st_q.irq_blk);

        st_d = st_q;
        if (ph1_en) st_d.irq_s1 = irq_act;
        if (ph2_en) begin
            st_d.irq_blk = brk_t6;
            if (brk_t6)                   st_d.int_s2 = 1'b0;
            else if (boundary && promote) st_d.int_s2 = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CORE_RST;
        else        st_q <= st_d;
    end

    assign force_brk   = st_q.int_s2;
    assign nmi_vec_sel = nmi_s1;
    assign brk_bit     = !(st_q.int_s2 || rst_stage2);
    assign set_idis    = brk_t0 && ph1_en;
endmodule

// File: rtl/irqnmi_stager_chk.sv
module irqnmi_stager_chk (
    input logic clk,
    input logic rst_n,
    input logic ph1_en,
    input logic ph2_en,
    input logic idis_flag,
    input logic t0_st,
    input logic t2_st,
    input logic is_branch,
    input logic br_pgcross,
    input logic brk_t6,
    input logic brk_t0,
    input logic rst_stage2,
    input logic force_brk,
    input logic nmi_vec_sel,
    input logic brk_bit,
    input logic set_idis
);
    logic at_edge;
    assign at_edge = is_branch ? (t2_st || (t0_st && br_pgcross)) : t0_st;

    // R3 R4: stage 2 rises only on a phase-2 boundary edge
    a_r3_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_brk) |-> $past(ph2_en && at_edge));

    // R8: BRK T6 phase 2 clears stage 2
    a_r8_t6_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2_en && brk_t6) |=> !force_brk);

    // R5: masked IRQ with no NMI cannot set stage 2
    a_r5_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2_en && idis_flag && !nmi_vec_sel && !force_brk) |=> !force_brk);

    // R6: NMI stage 1 rises on phase 1
    a_r6_vec_on_ph1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_vec_sel) |-> $past(ph1_en));

    // R9: NMI stage 1 falls only on BRK T0 phase 1
    a_r9_vec_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_vec_sel) |-> $past(ph1_en && brk_t0));

    // R9: disable-set strobe qualified by its inputs
    a_r9_set_idis: assert property (@(posedge clk) disable iff (!rst_n)
        set_idis |-> (brk_t0 && ph1_en));

    // R7: break bit low whenever a stage-2 source is active
    a_r7_brk_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (force_brk || rst_stage2) |-> !brk_bit);
endmodule

bind irqnmi_stager irqnmi_stager_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ph1_en(ph1_en), .ph2_en(ph2_en),
    .idis_flag(idis_flag), .t0_st(t0_st), .t2_st(t2_st), .is_branch(is_branch),
    .br_pgcross(br_pgcross), .brk_t6(brk_t6), .brk_t0(brk_t0),
    .rst_stage2(rst_stage2), .force_brk(force_brk), .nmi_vec_sel(nmi_vec_sel),
    .brk_bit(brk_bit), .set_idis(set_idis)
);

// File: tb/irqnmi_stager_tb.sv
`timescale 1ns/1ps
module irqnmi_stager_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ph1_en = 1'b0, ph2_en = 1'b0;
    logic irq_n = 1'b1, nmi_n = 1'b1, idis_flag = 1'b0;
    logic t0_st = 1'b0, t2_st = 1'b0, is_branch = 1'b0, br_pgcross = 1'b0;
    logic brk_t6 = 1'b0, brk_t0 = 1'b0, rst_stage2 = 1'b0;
    logic force_brk, nmi_vec_sel, brk_bit, set_idis;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic sid_p1, sid_p2, vec_p1;

    always #5 clk = ~clk;

    irqnmi_stager u_dut (
        .clk(clk), .rst_n(rst_n), .ph1_en(ph1_en), .ph2_en(ph2_en),
        .irq_n(irq_n), .nmi_n(nmi_n), .idis_flag(idis_flag),
        .t0_st(t0_st), .t2_st(t2_st), .is_branch(is_branch), .br_pgcross(br_pgcross),
        .brk_t6(brk_t6), .brk_t0(brk_t0), .rst_stage2(rst_stage2),
        .force_brk(force_brk), .nmi_vec_sel(nmi_vec_sel),
        .brk_bit(brk_bit), .set_idis(set_idis)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // one full machine cycle: phase-1 edge then phase-2 edge, status held
    task automatic cyc(input bit t0, input bit t2, input bit br, input bit pc,
                       input bit b6, input bit b0);
        @(negedge clk);
        t0_st = t0; t2_st = t2; is_branch = br; br_pgcross = pc;
        brk_t6 = b6; brk_t0 = b0; ph1_en = 1'b1; ph2_en = 1'b0;
        #1 sid_p1 = set_idis;
        @(posedge clk); #1 vec_p1 = nmi_vec_sel;
        @(negedge clk);
        ph1_en = 1'b0; ph2_en = 1'b1;
        #1 sid_p2 = set_idis;
        @(posedge clk); #1;
        @(negedge clk);
        ph2_en = 1'b0; t0_st = 1'b0; t2_st = 1'b0; is_branch = 1'b0;
        br_pgcross = 1'b0; brk_t6 = 1'b0; brk_t0 = 1'b0;
    endtask

    task automatic idle();  cyc(0, 0, 0, 0, 0, 0); endtask
    task automatic t0c();   cyc(1, 0, 0, 0, 0, 0); endtask

    task automatic clear_all();
        irq_n = 1'b1; nmi_n = 1'b1;
        cyc(0, 0, 0, 0, 1, 0);
        cyc(1, 0, 0, 0, 0, 1);
        for (int k = 0; k < 3; k++) idle();
        idis_flag = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R1 force_brk reset", force_brk, 1'b0);
        chk("R1 nmi_vec_sel reset", nmi_vec_sel, 1'b0);
        chk("R1 brk_bit reset", brk_bit, 1'b1);
        chk("R1 set_idis reset", set_idis, 1'b0);

        // non-branch IRQ
        irq_n = 1'b0;
        idle();               chk("R2 not promoted in sampling cycle", force_brk, 1'b0);
        cyc(0, 1, 0, 0, 0, 0); chk("R3 T2 ignored for non-branch", force_brk, 1'b0);
        t0c();                chk("R3 T0 promotes non-branch", force_brk, 1'b1);
        chk("R7 brk_bit low with force", brk_bit, 1'b0);
        chk("R6 IRQ gives no NMI vector", nmi_vec_sel, 1'b0);
        clear_all();          chk("R8 cleared after BRK", force_brk, 1'b0);
        chk("R7 brk_bit back high", brk_bit, 1'b1);

        // branches over every T-state / page-cross combination
        for (int pc = 0; pc < 2; pc++) begin
            irq_n = 1'b0;
            idle();
            cyc(1, 0, 1, pc[0], 0, 0);
            chk("R4 branch T0 needs page cross", force_brk, pc[0]);
            if (pc == 0) begin
                cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
                chk("R4 branch T2 promotes", force_brk, 1'b1);
            end
            clear_all();
        end

        // masked IRQ
        idis_flag = 1'b1; irq_n = 1'b0;
        idle();
        t0c(); chk("R5 masked at T0", force_brk, 1'b0);
        t0c(); chk("R5 still masked", force_brk, 1'b0);
        idis_flag = 1'b0;
        t0c(); chk("R5 promotes after unmask", force_brk, 1'b1);
        clear_all();

        // withdrawn IRQ
        irq_n = 1'b0;
        idle(); idle();
        irq_n = 1'b1;
        idle();
        t0c(); chk("R11 withdrawn IRQ not taken", force_brk, 1'b0);
        clear_all();

        // T6 hold-off
        irq_n = 1'b0;
        idle();
        t0c();                 chk("R8 setup promote", force_brk, 1'b1);
        cyc(0, 0, 0, 0, 1, 0); chk("R8 T6 clears stage 2", force_brk, 1'b0);
        t0c();                 chk("R8 IRQ blocked one cycle", force_brk, 1'b0);
        t0c();                 chk("R8 IRQ promotes after block", force_brk, 1'b1);
        clear_all();

        // NMI, held low across the clear, re-armed after it goes high
        idis_flag = 1'b1; nmi_n = 1'b0;
        idle();                chk("R2 NMI not latched yet", nmi_vec_sel, 1'b0);
        t0c();
        chk("R6 vector select at phase 1", vec_p1, 1'b1);
        chk("R6 NMI ignores disable flag", force_brk, 1'b1);
        cyc(0, 0, 0, 0, 1, 0); chk("R8 T6 clears NMI stage 2", force_brk, 1'b0);
        cyc(1, 0, 0, 0, 0, 1);
        chk("R9 set_idis during T0 phase 1", sid_p1, 1'b1);
        chk("R9 set_idis low in phase 2", sid_p2, 1'b0);
        chk("R9 vector select cleared", nmi_vec_sel, 1'b0);
        t0c(); t0c();
        chk("R10 held NMI not retaken", force_brk, 1'b0);
        chk("R10 held NMI no vector", nmi_vec_sel, 1'b0);
        nmi_n = 1'b1;
        idle();
        nmi_n = 1'b0;
        idle();
        t0c();
        chk("R10 re-armed after line high", force_brk, 1'b1);
        chk("R10 vector on re-armed NMI", nmi_vec_sel, 1'b1);

        // other order: line high before the clear
        nmi_n = 1'b1;
        idle();
        cyc(0, 0, 0, 0, 1, 0);
        cyc(1, 0, 0, 0, 0, 1);
        chk("R9 set_idis idle phase 2", sid_p2, 1'b0);
        nmi_n = 1'b0;
        idle();
        t0c();
        chk("R10 re-armed when line rose first", force_brk, 1'b1);
        clear_all();
        chk("R1 set_idis quiet", set_idis, 1'b0);

        // reset stage-2 input on break bit
        rst_stage2 = 1'b1;
        idle();
        chk("R7 brk_bit low for reset stage 2", brk_bit, 1'b0);
        chk("R7 reset stage 2 does not force", force_brk, 1'b0);
        rst_stage2 = 1'b0;
        idle();
        chk("R7 brk_bit restored", brk_bit, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule